// File: doc/BRIEF.md
# UART Receive/Transmit Line Status Logic

This block produces the 8-bit line status word for one UART channel that has 16-entry receive and transmit FIFOs. The receive character store lives inside the block. Each stored character carries three error tags: parity, framing and break. The block also sees the transmit FIFO fill level and whether the transmit shifter is busy. Host software reads the status word to learn whether receive data is waiting, whether errors occurred and whether the transmitter has drained. The block also flags polled operation. In that mode the FIFOs are on, every interrupt source is off, and the host works only by reading the status word.

The error bits for parity, framing and break describe only the character at the head of the receive store. A status read hides them until the next pop exposes a new head. A separate summary bit stays set while any stored character carries an error tag, and reads do not clear it. Overrun is sticky. It is set when a completed character finds the store full, and that character is dropped. With the FIFOs disabled, the store holds a single character.

Top module: `uls_line_status`

## Requirements
- R1: `polled_o` is 1 exactly when `fifo_en_i` is 1 and `ier_i` is zero. Any set interrupt-enable bit, or disabled FIFOs, makes it 0.
- R2: Status bit 0 (data ready) is 1 while at least one character is stored. It rises in the cycle after a push into an empty store.
- R3: Status bit 1 (overrun) is set in the cycle after a push arrives while the store is at capacity and no pop occurs in the same cycle. The pushed character is discarded. A push made with a same-cycle pop of a full store is accepted. A status read clears the bit, unless a new overrun occurs in that same cycle.
- R4: Status bits 2, 3 and 4 are the parity, framing and break tags of the head character. After a status read they read 0 until a pop brings a new character to the head.
- R5: Status bit 5 is 1 when the transmit FIFO level is zero.
- R6: Status bit 6 is 1 only when the transmit FIFO level is zero and the transmit shifter is idle.
- R7: Status bit 7 is 1 while any stored character has any error tag. A status read does not clear it. It drops when the last tagged character is popped.
- R8: Store capacity is 16 characters with the FIFOs enabled and 1 character with them disabled.
- R9: Characters leave in arrival order and `rx_head_o` shows the head character. A pop when the store is empty is ignored.
- R10: When a status read and a pop happen in the same cycle, the error tags of the newly exposed head are shown unmasked.
- R11: After reset the store is empty and overrun is clear. The status word then depends only on the transmit inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | FIFOs enabled |
| ier_i | input | 4 | Interrupt enable bits |
| rx_push_i | input | 1 | Received character complete |
| rx_data_i | input | 8 | Received character |
| rx_par_err_i | input | 1 | Parity error tag of the incoming character |
| rx_frm_err_i | input | 1 | Framing error tag of the incoming character |
| rx_brk_i | input | 1 | Break tag of the incoming character |
| rx_pop_i | input | 1 | Host reads the head character |
| lsr_rd_i | input | 1 | Host reads the status word |
| tx_level_i | input | 5 | Transmit FIFO fill level |
| tx_shift_busy_i | input | 1 | Transmit shifter busy |
| lsr_o | output | 8 | Line status word |
| rx_head_o | output | 8 | Head character of the receive store |
| polled_o | output | 1 | Polled mode, interrupts suppressed |

## Verification
The store is tried with clean characters followed by a tagged one. This separates the head-only error bits from the whole-store summary bit, because bit 7 rises while bits 2 to 4 stay low. A fill to sixteen characters followed by an extra push, a push with a same-cycle pop, and a full drain with the data compared shows that overrun, drop and acceptance are decided against the true capacity and that order is kept. A status read alone, and a status read combined with a pop, show which bits a read masks and that a new head is exposed unmasked. The single-entry mode and interrupt-enable patterns separate the two capacities and the polled flag cases.

// File: rtl/uls_pkg.sv
package uls_pkg;

    // error tags kept beside every stored receive character
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_tag_t;

    // status word, most significant field first (bit 7 down to bit 0)
    typedef struct packed {
        logic fifo_err;
        logic tx_idle;
        logic tx_empty;
        logic brk;
        logic frm;
        logic par;
        logic ovr;
        logic ready;
    } lsr_t;

endpackage

// File: rtl/uls_rx_store.sv
module uls_rx_store
    import uls_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         fifo_en_i,
    input  logic                         push_i,
    input  logic                         pop_i,
    input  logic [DW-1:0]                wdata_i,
    input  rx_tag_t                      wtag_i,
    output logic [DW-1:0]                head_data_o,
    output rx_tag_t                      head_tag_o,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic                         any_err_o,
    output logic                         push_ok_o,
    output logic                         pop_ok_o,
    output logic                         overflow_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]    wr;
        logic [PW-1:0]    rd;
        logic [CW-1:0]    cnt;
        logic [DEPTH-1:0] err;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [CW-1:0] cap;
    logic          push_ok, pop_ok;
    logic [DW-1:0] dat_q [DEPTH];
    rx_tag_t       tag_q [DEPTH];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap     = fifo_en_i ? CW'(DEPTH) : CW'(1);
        pop_ok  = pop_i && (ctl_q.cnt != '0);
        push_ok = push_i && ((ctl_q.cnt < cap) || pop_ok);
        ctl_d   = ctl_q;
        if (pop_ok) begin
            ctl_d.rd          = nxt(ctl_q.rd);
            ctl_d.err[ctl_q.rd] = 1'b0;
        end
        if (push_ok) begin
            ctl_d.wr          = nxt(ctl_q.wr);
            ctl_d.err[ctl_q.wr] = |wtag_i;
        end
        ctl_d.cnt = ctl_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                dat_q[i] <= '0;
                tag_q[i] <= '0;
            end else if (push_ok && (ctl_q.wr == PW'(i))) begin
                dat_q[i] <= wdata_i;
                tag_q[i] <= wtag_i;
            end
        end
    end

    always_comb begin
        head_data_o = dat_q[ctl_q.rd];
        head_tag_o  = (ctl_q.cnt != '0) ? tag_q[ctl_q.rd] : '0;
        cnt_o       = ctl_q.cnt;
        any_err_o   = |ctl_q.err;
        push_ok_o   = push_ok;
        pop_ok_o    = pop_ok;
        overflow_o  = push_i && !push_ok;
    end

endmodule

// File: rtl/uls_flag_keeper.sv
module uls_flag_keeper (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic overflow_i,
    input  logic pop_ok_i,
    input  logic rd_i,
    input  logic stored_i,
    output logic ovr_o,
    output logic head_ack_o
);
    typedef struct packed {
        logic ovr;
        logic ack;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d     = flg_q;
        // a new overrun wins over a clearing read in the same cycle
        flg_d.ovr = overflow_i || (flg_q.ovr && !rd_i);
        // the read hides the current head only; a pop exposes a fresh head
        flg_d.ack = stored_i && !pop_ok_i && (flg_q.ack || rd_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flg_q <= '0;
        else         flg_q <= flg_d;
    end

    assign ovr_o      = flg_q.ovr;
    assign head_ack_o = flg_q.ack;

endmodule

// File: rtl/uls_tx_view.sv
module uls_tx_view #(
    parameter int TCW = 5
) (
    input  logic [TCW-1:0] level_i,
    input  logic           busy_i,
    output logic           empty_o,
    output logic           idle_o
);
    always_comb begin
        empty_o = (level_i == '0);
        idle_o  = empty_o && !busy_i;
    end
endmodule

// File: rtl/uls_line_status.sv
module uls_line_status
    import uls_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int NIER  = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          fifo_en_i,
    input  logic [NIER-1:0]               ier_i,
    input  logic                          rx_push_i,
    input  logic [DW-1:0]                 rx_data_i,
    input  logic                          rx_par_err_i,
    input  logic                          rx_frm_err_i,
    input  logic                          rx_brk_i,
    input  logic                          rx_pop_i,
    input  logic                          lsr_rd_i,
    input  logic [$clog2(DEPTH+1)-1:0]    tx_level_i,
    input  logic                          tx_shift_busy_i,
    output logic [7:0]                    lsr_o,
    output logic [DW-1:0]                 rx_head_o,
    output logic                          polled_o
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_tag_t       in_tag, head_tag;
    logic [CW-1:0] rx_cnt;
    logic          any_err, push_ok, pop_ok, overflow;
    logic          ovr, head_ack, tx_empty, tx_idle;
    lsr_t          lsr;

    assign in_tag = '{brk: rx_brk_i, frm: rx_frm_err_i, par: rx_par_err_i};

    uls_rx_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fifo_en_i   (fifo_en_i),
        .push_i      (rx_push_i),
        .pop_i       (rx_pop_i),
        .wdata_i     (rx_data_i),
        .wtag_i      (in_tag),
        .head_data_o (rx_head_o),
        .head_tag_o  (head_tag),
        .cnt_o       (rx_cnt),
        .any_err_o   (any_err),
        .push_ok_o   (push_ok),
        .pop_ok_o    (pop_ok),
        .overflow_o  (overflow)
    );

    uls_flag_keeper u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .overflow_i (overflow),
        .pop_ok_i   (pop_ok),
        .rd_i       (lsr_rd_i),
        .stored_i   (rx_cnt != '0),
        .ovr_o      (ovr),
        .head_ack_o (head_ack)
    );

    uls_tx_view #(.TCW(CW)) u_tx (
        .level_i (tx_level_i),
        .busy_i  (tx_shift_busy_i),
        .empty_o (tx_empty),
        .idle_o  (tx_idle)
    );

    always_comb begin
        lsr.ready    = (rx_cnt != '0);
        lsr.ovr      = ovr;
        lsr.par      = head_tag.par && !head_ack;
        lsr.frm      = head_tag.frm && !head_ack;
        lsr.brk      = head_tag.brk && !head_ack;
        lsr.tx_empty = tx_empty;
        lsr.tx_idle  = tx_idle;
        lsr.fifo_err = any_err;
        lsr_o        = lsr;
        polled_o     = fifo_en_i && (ier_i == '0);
    end

    logic unused_ok;
    assign unused_ok = push_ok;

endmodule

// File: rtl/uls_line_status_chk.sv
module uls_line_status_chk #(
    parameter int DEPTH = 16,
    parameter int NIER  = 4
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        fifo_en_i,
    input logic [NIER-1:0]             ier_i,
    input logic                        rx_push_i,
    input logic                        rx_pop_i,
    input logic                        lsr_rd_i,
    input logic [7:0]                  lsr_o,
    input logic                        polled_o,
    input logic [$clog2(DEPTH+1)-1:0]  rx_cnt
);
    localparam int CW = $clog2(DEPTH + 1);
    logic [CW-1:0] cap;
    logic          full_push;
    assign cap       = fifo_en_i ? CW'(DEPTH) : CW'(1);
    assign full_push = rx_push_i && !rx_pop_i && (rx_cnt >= cap);

    AST_POLLED_IER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ier_i != '0) |-> !polled_o); // R1
    AST_READY_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_push_i && rx_cnt == '0) |=> lsr_o[0]); // R2
    AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_push |=> lsr_o[1]); // R3
    AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lsr_rd_i && !full_push) |=> !lsr_o[1]); // R3
    AST_HEAD_ERR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|lsr_o[4:2]) |-> lsr_o[0]); // R4
    AST_IDLE_IMPLIES_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lsr_o[6] |-> lsr_o[5]); // R6
    AST_FIFO_ERR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lsr_o[7] |-> lsr_o[0]); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_cnt <= CW'(DEPTH)); // R8
    AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_pop_i && !rx_push_i && rx_cnt == '0) |=> (rx_cnt == '0)); // R9

endmodule

bind uls_line_status uls_line_status_chk #(.DEPTH(DEPTH), .NIER(NIER)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .ier_i     (ier_i),
    .rx_push_i (rx_push_i),
    .rx_pop_i  (rx_pop_i),
    .lsr_rd_i  (lsr_rd_i),
    .lsr_o     (lsr_o),
    .polled_o  (polled_o),
    .rx_cnt    (rx_cnt)
);

// File: tb/uls_line_status_tb_top.sv
module uls_line_status_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [3:0] ier = 4'd0;
    logic       push = 1'b0, pop = 1'b0, rd = 1'b0;
    logic [7:0] din = 8'd0;
    logic       par = 1'b0, frm = 1'b0, brk = 1'b0;
    logic [4:0] tx_lvl = 5'd0;
    logic       tx_busy = 1'b0;
    logic [7:0] lsr, head;
    logic       polled;

    always #(CLK_P/2) clk = ~clk;

    uls_line_status dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .ier_i(ier),
        .rx_push_i(push), .rx_data_i(din), .rx_par_err_i(par),
        .rx_frm_err_i(frm), .rx_brk_i(brk), .rx_pop_i(pop), .lsr_rd_i(rd),
        .tx_level_i(tx_lvl), .tx_shift_busy_i(tx_busy),
        .lsr_o(lsr), .rx_head_o(head), .polled_o(polled)
    );

    typedef struct {
        logic [7:0] lsr;
        logic [7:0] head;
        bit         hv;
        logic       pol;
        string      req;
    } exp_t;

    exp_t        exp_q[$];
    logic [10:0] mq[$];
    bit          m_ovr = 0, m_ack = 0;
    int          nvec = 0, nmis = 0;
    bit          done = 0;
    logic [4:0]  m_lvl = 5'd0;
    bit          m_busy = 0, m_fen = 1;
    logic [3:0]  m_ier = 4'd0;

    function automatic exp_t model_out(string req);
        exp_t e;
        logic [2:0] t;
        bit anyerr = 0;
        e.lsr = 8'd0;
        e.lsr[0] = (mq.size() > 0);
        e.lsr[1] = m_ovr;
        if (mq.size() > 0 && !m_ack) begin
            t = mq[0][10:8];
            e.lsr[2] = t[0];
            e.lsr[3] = t[1];
            e.lsr[4] = t[2];
        end
        e.lsr[5] = (m_lvl == 0);
        e.lsr[6] = (m_lvl == 0) && !m_busy;
        foreach (mq[i]) if (mq[i][10:8] != 0) anyerr = 1;
        e.lsr[7] = anyerr;
        e.hv   = (mq.size() > 0);
        e.head = e.hv ? mq[0][7:0] : 8'd0;
        e.pol  = m_fen && (m_ier == 0);
        e.req  = req;
        return e;
    endfunction

    // driver: one cycle of stimulus; model update; expected item queued
    task automatic step(bit p_push, bit p_pop, bit p_rd, logic [7:0] d,
                        logic [2:0] tg, string req);
        int  cap;
        bit  pe, acc, ov;
        @(negedge clk);
        push = p_push; pop = p_pop; rd = p_rd; din = d;
        par = tg[0]; frm = tg[1]; brk = tg[2];
        tx_lvl = m_lvl; tx_busy = m_busy; fifo_en = m_fen; ier = m_ier;
        cap = m_fen ? DEPTH : 1;
        pe  = p_pop && (mq.size() > 0);
        acc = p_push && ((mq.size() < cap) || pe);
        ov  = p_push && !acc;
        m_ack = (mq.size() != 0) && !pe && (m_ack || p_rd);
        m_ovr = ov || (m_ovr && !p_rd);
        if (pe) void'(mq.pop_front());
        if (acc) mq.push_back({tg, d});
        exp_q.push_back(model_out(req));
        @(posedge clk);
        #2;
        push = 0; pop = 0; rd = 0;
    endtask

    task automatic idle(string req);
        step(0, 0, 0, 8'd0, 3'd0, req);
    endtask

    // monitor: compares each queued expectation after the clock edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            nvec++;
            if (lsr !== e.lsr || polled !== e.pol || (e.hv && head !== e.head)) begin
                nmis++;
                $display("FAIL %s: lsr=%02h head=%02h polled=%0b expected lsr=%02h head=%02h polled=%0b",
                         e.req, lsr, head, polled, e.lsr, e.head, e.pol);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            nmis++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle("R11 reset state");
        // R1 polled flag
        m_ier = 4'b0010; idle("R1 ier set");
        m_ier = 4'b0000; m_fen = 0; idle("R1 fifo off");
        m_fen = 1; idle("R1 polled");
        // R5 / R6 transmit view
        m_lvl = 5'd3; idle("R5 tx level 3");
        m_lvl = 5'd0; m_busy = 1; idle("R6 shifter busy");
        m_busy = 0; idle("R6 tx drained");
        // R2, R4, R7 head-only flags versus summary bit
        step(1, 0, 0, 8'hA1, 3'b000, "R2 clean push");
        step(1, 0, 0, 8'hB2, 3'b001, "R7 tagged behind clean head");
        step(0, 1, 0, 8'd0, 3'd0, "R4 parity head exposed");
        step(0, 0, 1, 8'd0, 3'd0, "R4 read hides head flags");
        idle("R7 summary survives read");
        step(0, 1, 0, 8'd0, 3'd0, "R7 last tagged popped");
        // R10 read with pop exposes new head unmasked
        step(1, 0, 0, 8'hC3, 3'b010, "R4 framing head");
        step(1, 0, 0, 8'hD4, 3'b100, "R4 break behind");
        step(0, 1, 1, 8'd0, 3'd0, "R10 read plus pop");
        step(0, 0, 1, 8'd0, 3'd0, "R4 read masks break");
        step(0, 1, 0, 8'd0, 3'd0, "R9 drain");
        step(0, 1, 0, 8'd0, 3'd0, "R9 pop empty ignored");
        // R8 / R3 fill, overrun, full push with pop
        for (int i = 0; i < DEPTH; i++)
            step(1, 0, 0, 8'(8'h10 + i), (i == 5) ? 3'b001 : 3'b000, "R8 fill");
        step(1, 0, 0, 8'hEE, 3'b000, "R3 overrun on full");
        idle("R3 overrun sticky");
        step(0, 0, 1, 8'd0, 3'd0, "R3 read clears overrun");
        step(1, 1, 0, 8'h77, 3'b000, "R3 full push with pop accepted");
        step(1, 0, 1, 8'h88, 3'b000, "R3 overrun wins over read");
        step(0, 0, 1, 8'd0, 3'd0, "R3 read clears");
        for (int i = 0; i < DEPTH; i++)
            step(0, 1, 0, 8'd0, 3'd0, "R9 order on drain");
        // R8 single-entry mode
        m_fen = 0;
        step(1, 0, 0, 8'h31, 3'b000, "R8 single entry push");
        step(1, 0, 0, 8'h32, 3'b010, "R8 second push overruns");
        step(0, 1, 1, 8'd0, 3'd0, "R8 pop single");
        m_fen = 1;
        idle("R1 back to polled");
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule